// File: doc/BRIEF.md
# Set-Associative Tag Directory with Recency Ordering

This block classifies memory accesses as hits or misses against a set-associative tag directory. It stores no data. A requester presents a byte address and an access length over a valid/ready handshake. For each accepted access the block returns one result pulse and updates its stored tags. It allocates on every miss, whether the access is a read or a write. Inside each set the ways are kept in recency order by physically shifting tags: slot 0 always holds the most recently used tag, and the last slot holds the eviction candidate.

Line size, set count and associativity are power-of-two parameters. Associativity may be 1, which gives a direct-mapped directory. An access whose bytes cover two neighbouring lines probes both sets, one per cycle, using the tag of its first byte, and reports a single combined result. An access whose first and last bytes fall in sets that are neither equal nor neighbouring produces an error response and leaves the directory untouched.

Top module: `tag_directory`

## Requirements
- R1: The set index is `(addr >> log2(LINE_BYTES)) & (SETS-1)` and the tag is `addr >> (log2(LINE_BYTES)+log2(SETS))`; the byte offset inside a line does not affect the result.
- R2: Reset clears every slot to tag 0 with no valid bits, so an access with tag 0 hits right after reset; in reset `req_ready` is 1 and `rsp_valid` is 0.
- R3: A tag found in slot 0 reports a hit (`rsp_miss`=0) and leaves the set unchanged.
- R4: A tag found in slot i>0 reports a hit; slots 0..i-1 each move down one place and the tag is written to slot 0, so it becomes the last to be evicted.
- R5: A miss (`rsp_miss`=1) shifts every slot down one place, drops the tag in the last slot and installs the new tag in slot 0; `rsp_miss` is only ever high together with `rsp_valid`.
- R6: When the last byte (`addr + req_len_m1`) lies in the set following the first byte's set, both sets are probed and updated with the first byte's tag; the single result is a miss if either probe misses and a hit only if both hit.
- R7: A two-set access holds `req_ready` low for exactly the one cycle after acceptance, and its response arrives two cycles after acceptance; no response is issued during that busy cycle.
- R8: When the first and last byte sets are neither equal nor neighbouring, the response has `rsp_error`=1 and `rsp_miss`=0, and no set is modified.
- R9: A single-set or error access gets its response in the cycle after acceptance; every accepted access gets exactly one one-cycle `rsp_valid` pulse.
- R10: Neighbouring sets wrap from set SETS-1 to set 0, and the second probe then still uses the first byte's tag rather than the tag of the wrapped address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Directory can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the first byte accessed |
| req_len_m1 | input | 3 | Access length minus one (0 = 1 byte, 7 = 8 bytes) |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_miss | output | 1 | 1 = miss, 0 = hit; valid with rsp_valid |
| rsp_error | output | 1 | Access spans non-neighbouring sets; valid with rsp_valid |

## Verification
The main function is exercised in five ways. Filling one set and then touching its slot-0 and deeper tags separates the front-hit case from the move-to-front case. A following chain of evictions shows whether the correct oldest tag was dropped. Two-set accesses are driven with both halves absent, only the first present and only the second present, which shows whether the results are combined rather than reported separately. A wrapped two-set access, followed by single probes of the wrapped set, tells the first-byte tag apart from the tag of the wrapped address. A long pseudo-random stream over a small tag pool, checked against a bench-side recency list, mixes all of these with back-to-back timing.

// File: rtl/tag_directory.sv
module tag_directory #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 4,
  parameter int SETS       = 8,
  parameter int WAYS       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_len_m1,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic              rsp_error
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int IDX_B = $clog2(SETS);
  localparam int SET_W = (IDX_B > 0) ? IDX_B : 1;
  localparam int SHIFT = OFS_W + IDX_B;
  localparam int TAG_W = ADDR_W - SHIFT;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return SET_W'((a >> OFS_W) & ADDR_W'(SETS - 1));
  endfunction

  logic [TAG_W-1:0] tags [SETS][WAYS];

  logic              busy, miss_q;
  logic [SET_W-1:0]  set_b_q;
  logic [TAG_W-1:0]  tag_q;

  logic [ADDR_W-1:0] last_addr;
  logic [SET_W-1:0]  set_a, set_b, set_next;
  logic [TAG_W-1:0]  tag_a;
  logic              span, bad, accept, probe_en;

  assign last_addr = req_addr + ADDR_W'(req_len_m1);
  assign set_a     = set_of(req_addr);
  assign set_b     = set_of(last_addr);
  assign set_next  = SET_W'((32'(set_a) + 1) & (SETS - 1));
  assign tag_a     = TAG_W'(req_addr >> SHIFT);
  assign span      = set_a != set_b;
  assign bad       = span && (set_b != set_next);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign probe_en  = busy || (accept && !bad);

  logic [SET_W-1:0] p_set;
  logic [TAG_W-1:0] p_tag;
  assign p_set = busy ? set_b_q : set_a;
  assign p_tag = busy ? tag_q : tag_a;

  logic [TAG_W-1:0] row     [WAYS];
  logic [TAG_W-1:0] new_row [WAYS];
  logic             hit;
  int               pos;

  always_comb begin
    hit = 1'b0;
    pos = WAYS - 1;
    for (int i = 0; i < WAYS; i++) row[i] = tags[p_set][i];
    for (int i = 0; i < WAYS; i++) begin
      if (!hit && row[i] == p_tag) begin
        hit = 1'b1;
        pos = i;
      end
    end
    new_row[0] = p_tag;
    for (int i = 1; i < WAYS; i++)
      new_row[i] = (i <= pos) ? row[i-1] : row[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          tags[s][w] <= '0;
      busy      <= 1'b0;
      miss_q    <= 1'b0;
      set_b_q   <= '0;
      tag_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_error <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_error <= 1'b0;
      if (probe_en)
        for (int w = 0; w < WAYS; w++)
          tags[p_set][w] <= new_row[w];
      if (busy) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_miss  <= miss_q | ~hit;
      end else if (accept) begin
        if (bad) begin
          rsp_valid <= 1'b1;
          rsp_error <= 1'b1;
        end else if (span) begin
          busy    <= 1'b1;
          miss_q  <= ~hit;
          set_b_q <= set_b;
          tag_q   <= tag_a;
        end else begin
          rsp_valid <= 1'b1;
          rsp_miss  <= ~hit;
        end
      end
    end
  end
endmodule

// File: rtl/tag_directory_chk.sv
module tag_directory_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_miss,
  input logic rsp_error
);
  AST_ERROR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_valid && !rsp_miss); // R8
  AST_MISS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_valid); // R5
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R7
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rsp_valid); // R7
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready))); // R9
endmodule

bind tag_directory tag_directory_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_error(rsp_error)
);

// File: tb/test_tag_directory.sv
module test_tag_directory;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, LINE_BYTES = 4, SETS = 8, WAYS = 4;
  localparam int TAG_W = ADDR_W - 5;

  logic              clk = 0, rst_n = 0, req_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_len_m1 = '0;
  logic              req_ready, rsp_valid, rsp_miss, rsp_error;

  tag_directory #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS))
    i_tag_directory (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
                     .req_addr(req_addr), .req_len_m1(req_len_m1), .rsp_valid(rsp_valid),
                     .rsp_miss(rsp_miss), .rsp_error(rsp_error));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; bit miss; bit err; string req; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  bit finished = 0;
  logic [TAG_W-1:0] mtag [SETS][WAYS];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
    return {TAG_W'(t), 3'(s), 2'(o)};
  endfunction

  task automatic mprobe(input int s, input logic [TAG_W-1:0] t, output bit miss);
    int pos;
    pos = WAYS - 1;
    miss = 1;
    for (int i = 0; i < WAYS; i++)
      if (miss && mtag[s][i] == t) begin miss = 0; pos = i; end
    for (int i = pos; i > 0; i--) mtag[s][i] = mtag[s][i-1];
    mtag[s][0] = t;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int len, input string req);
    logic [ADDR_W-1:0] last;
    int s1, s2;
    logic [TAG_W-1:0] t;
    bit m1, m2, span;
    exp_t e;
    while (!req_ready) @(negedge clk);
    last = a + ADDR_W'(len - 1);
    s1 = int'((a >> 2) & 7);
    s2 = int'((last >> 2) & 7);
    t = TAG_W'(a >> 5);
    e.req = req; e.err = 0; e.miss = 0; span = 0;
    if (s1 == s2) begin
      mprobe(s1, t, m1); e.miss = m1; e.due = cyc + 1;
    end else if (s2 == (s1 + 1) % SETS) begin
      mprobe(s1, t, m1); mprobe(s2, t, m2);
      e.miss = m1 | m2; e.due = cyc + 2; span = 1;
    end else begin
      e.err = 1; e.due = cyc + 1;
    end
    q.push_back(e);
    req_valid = 1; req_addr = a; req_len_m1 = 3'(len - 1);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == !span, "R7", "ready after accept", int'(req_ready), int'(!span));
  endtask

  exp_t got;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (q.size() == 0) check(0, "R9", "unexpected response", 1, 0);
        else begin
          got = q.pop_front();
          check(cyc == got.due, got.req, "response cycle", cyc, got.due);
          check(rsp_error == got.err, got.req, "rsp_error", int'(rsp_error), int'(got.err));
          check(rsp_miss == got.miss, got.req, "rsp_miss", int'(rsp_miss), int'(got.miss));
        end
      end else if (q.size() > 0 && q[0].due < cyc) begin
        check(0, q[0].req, "missing response", cyc, q[0].due);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R9", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    logic [15:0] r;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) mtag[s][w] = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R2", "ready in reset", int'(req_ready), 1);
    check(rsp_valid == 0, "R2", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    access(mk(0, 0, 0), 1, "R2");
    // R1: offset within the line does not matter
    access(mk(5, 4, 0), 1, "R1");
    access(mk(5, 4, 3), 1, "R1");
    access(mk(5, 4, 1), 2, "R1");
    access(mk(6, 4, 0), 1, "R1");
    // R5 fill, R3 front hit, R4 deeper hit, eviction order
    for (int t = 1; t <= 4; t++) access(mk(t, 1, 0), 1, "R5");
    access(mk(4, 1, 0), 1, "R3");
    access(mk(4, 1, 2), 1, "R3");
    access(mk(1, 1, 0), 1, "R4");
    access(mk(9, 1, 0), 1, "R5");
    access(mk(2, 1, 0), 1, "R5");
    access(mk(1, 1, 0), 1, "R4");
    access(mk(3, 1, 0), 1, "R5");
    access(mk(1, 1, 0), 1, "R4");
    // R6: two-set accesses
    access(mk(20, 2, 3), 2, "R6");
    access(mk(20, 2, 3), 2, "R6");
    access(mk(21, 2, 0), 1, "R6");
    access(mk(21, 2, 2), 4, "R6");
    access(mk(21, 2, 2), 4, "R6");
    access(mk(22, 3, 0), 1, "R6");
    access(mk(22, 2, 3), 2, "R6");
    access(mk(22, 2, 3), 2, "R6");
    // R8: non-neighbouring sets, nothing installed
    access(mk(30, 5, 3), 8, "R8");
    access(mk(30, 5, 0), 1, "R8");
    access(mk(30, 7, 0), 1, "R8");
    // R10: wrap from last set to set 0 with the first byte's tag
    access(mk(40, 7, 2), 4, "R10");
    access(mk(40, 0, 0), 1, "R10");
    access(mk(41, 0, 0), 1, "R10");
    access(mk(40, 7, 0), 1, "R10");
    // mixed stream
    r = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      access(mk(int'(r[2:0]), int'(r[5:3]), int'(r[7:6])), int'(r[10:8]) + 1, "R5");
    end
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R9", "responses outstanding", q.size(), 0);
    summary();
  end
endmodule